// File: doc/BRIEF.md
# Store Queue Commit and Writeback

This block holds the stores of an out-of-order core between dispatch and the data cache. Stores enter at the tail in program order, each with a sequence number. Execution later fills in each store's byte count and data. A commit pulse carries the youngest retired sequence number. Every store up to that point is then marked as ready to drain. Ready stores go out one at a time, in order, from a separate drain pointer to a cache request port. That port has a ready signal and a retry signal. The cache answers each accepted store with a response that carries the slot index sent with the request. The head then releases every contiguous finished slot at once.

A squash pulse carries a sequence number. It trims younger stores off the tail, but it never removes a store that has already been marked ready. A static ordering input selects between two modes. In the relaxed mode, stores stream to the cache back to back. In the total-store-order mode, only one store may be outstanding at a time. The ring has one spare slot beyond its capacity, so that a full ring and an empty ring can be told apart.

Top module: `sq_store_queue`

## Requirements
- R1: After reset the ring is empty: `free_cnt` equals DEPTH, `alloc_idx` is 0 and `req_valid` is low.
- R2: An accepted allocation writes the store into slot `alloc_idx`. The next slot index is that slot plus one, modulo DEPTH+1. `free_cnt` always equals DEPTH minus the number of stores between head and tail.
- R3: An allocation while `free_cnt` is 0 is dropped and leaves `alloc_idx` unchanged. An allocation in a cycle with `squash_valid` high is also dropped.
- R4: A commit walks from the head toward the tail and marks each unmarked store as ready. It stops at the first unmarked store whose sequence number is greater than `commit_seq`. Stores beyond that point never raise `req_valid`.
- R5: `req_valid` is raised for the slot at the drain pointer only when that slot is marked ready and has a nonzero size. `req_idx`, `req_size` and `req_data` describe that slot. When `req_ready` is high, the drain pointer moves to the next slot on the following cycle. In relaxed mode the next ready store is offered in that cycle.
- R6: A ready store of size 0 raises no request. It is finished in the cycle it reaches the drain pointer, and the drain pointer moves past it.
- R7: A request refused with `req_ready` low leaves the drain pointer on that slot. `req_valid` then stays low except in cycles where `retry_in` is high. In those cycles the same slot is offered again.
- R8: A response with `rsp_valid` marks slot `rsp_idx` finished. The head moves past every consecutive finished slot starting at the head. A finished slot that is not at the head frees nothing until the slots ahead of it finish.
- R9: A squash removes stores from the tail backwards while their sequence number is greater than `squash_seq`. It stops at the first store that is marked ready or is not younger. `alloc_idx` then points just past the last kept store.
- R10: While `tso_order` is high, a store accepted by the cache blocks any further `req_valid` until a store finishes, either by a response or by the size-0 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tso_order | input | 1 | 1 = at most one store outstanding |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx | output | IDX_W | Slot the next allocation will take |
| free_cnt | output | CNT_W | Number of stores that can still be allocated |
| exec_valid | input | 1 | Execution result for one slot |
| exec_idx | input | IDX_W | Slot being filled |
| exec_size | input | SIZE_W | Byte count of the store, 0 = no data |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit pulse |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash pulse |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| req_valid | output | 1 | Cache store request offered |
| req_ready | input | 1 | Cache accepts the offered request |
| req_idx | output | IDX_W | Slot index sent with the request |
| req_size | output | SIZE_W | Byte count of the request |
| req_data | output | DATA_W | Data of the request |
| retry_in | input | 1 | Cache asks for the refused request again |
| rsp_valid | input | 1 | Cache has finished one store |
| rsp_idx | input | IDX_W | Slot index of the finished store |

## Verification
The request outputs are combinational from state and from `retry_in`, so a request is due in the same cycle as the state that allows it. Effects of allocation, commit, squash, refusal and response appear one rising edge later: in `alloc_idx`, `free_cnt` and the next request. The bench drives inputs just after a rising edge and compares every output on the falling edge of the same cycle. It steps a queue model at each rising edge, which keeps every comparison aligned to that one-edge latency. The directed checks read the ports shortly after the edge that applied the stimulus.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Position arithmetic on a ring of n slots; accepts negative offsets.
  function automatic int sq_wrap(input int pos, input int n);
    return ((pos % n) + n) % n;
  endfunction

  // Number of slots from 'first' up to (not including) 'last'.
  function automatic int sq_span(input int first, input int last, input int n);
    return sq_wrap(last - first, n);
  endfunction

endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan
  import sq_pkg::*;
#(
  parameter int N     = 9,
  parameter int IDX_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic [SEQ_W-1:0] seq [N],
  input  logic [N-1:0]     ready_q,
  output logic [N-1:0]     ready_set
);
  logic             halt;
  int               occ;
  logic [IDX_W-1:0] pos;

  always_comb begin
    ready_set = '0;
    halt      = !commit_valid;
    occ       = sq_span(int'(head), int'(tail), N);
    pos       = head;
    for (int k = 0; k < N; k++) begin
      pos = IDX_W'(sq_wrap(int'(head) + k, N));
      if (!halt && k < occ && !ready_q[pos]) begin
        if (seq[pos] > commit_seq) halt = 1'b1;
        else                       ready_set[pos] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan
  import sq_pkg::*;
#(
  parameter int N     = 9,
  parameter int IDX_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [SEQ_W-1:0] seq [N],
  input  logic [N-1:0]     ready_now,
  output logic [IDX_W-1:0] cut_tail
);
  logic             halt;
  int               occ;
  logic [IDX_W-1:0] pos;

  always_comb begin
    cut_tail = tail;
    halt     = !squash_valid;
    occ      = sq_span(int'(head), int'(tail), N);
    pos      = tail;
    for (int k = 0; k < N; k++) begin
      pos = IDX_W'(sq_wrap(int'(tail) - 1 - k, N));
      if (!halt && k < occ) begin
        if (ready_now[pos] || seq[pos] <= squash_seq) halt = 1'b1;
        else                                          cut_tail = pos;
      end
    end
  end
endmodule

// File: rtl/sq_head_scan.sv
module sq_head_scan
  import sq_pkg::*;
#(
  parameter int N     = 9,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  input  logic [N-1:0]     done_now,
  output logic [IDX_W-1:0] new_head,
  output logic [N-1:0]     release_mask
);
  logic             halt;
  int               occ;
  logic [IDX_W-1:0] pos;

  always_comb begin
    new_head     = head;
    release_mask = '0;
    halt         = 1'b0;
    occ          = sq_span(int'(head), int'(tail), N);
    pos          = head;
    for (int k = 0; k < N; k++) begin
      pos = IDX_W'(sq_wrap(int'(head) + k, N));
      if (!halt && k < occ) begin
        if (done_now[pos]) begin
          release_mask[pos] = 1'b1;
          new_head          = IDX_W'(sq_wrap(int'(pos) + 1, N));
        end else begin
          halt = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
  import sq_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int SEQ_W  = 16,
  parameter  int DATA_W = 64,
  parameter  int SIZE_W = 4,
  localparam int N      = DEPTH + 1,
  localparam int IDX_W  = $clog2(N),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tso_order,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic [CNT_W-1:0]  free_cnt,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_idx,
  output logic [SIZE_W-1:0] req_size,
  output logic [DATA_W-1:0] req_data,
  input  logic              retry_in,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_idx
);
  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
    return IDX_W'(sq_wrap(int'(p) + 1, N));
  endfunction

  // Slot storage
  logic [SEQ_W-1:0]  seq_q  [N];
  logic [SIZE_W-1:0] size_q [N];
  logic [DATA_W-1:0] data_q [N];
  logic [N-1:0]      ready_q, done_q;

  // Pointers and drain state
  logic [IDX_W-1:0] head_q, tail_q, wb_q;
  logic             blocked_q, inflight_q;

  // Named internal events
  int               occ_cnt;
  logic             ring_full, alloc_take;
  logic             wb_elig, wb_zero, wb_sent, wb_refused, wb_blocked, tso_busy;
  logic             store_done;
  logic [N-1:0]     ready_set, ready_now, done_now, release_mask;
  logic [IDX_W-1:0] cut_tail, new_head;

  assign occ_cnt    = sq_span(int'(head_q), int'(tail_q), N);
  assign ring_full  = (occ_cnt == DEPTH);
  assign alloc_take = alloc_valid && !ring_full && !squash_valid;
  assign free_cnt   = CNT_W'(DEPTH - occ_cnt);
  assign alloc_idx  = tail_q;

  assign wb_blocked = blocked_q;
  assign tso_busy   = tso_order && inflight_q;
  assign wb_elig    = (wb_q != tail_q) && ready_q[wb_q] && !tso_busy;
  assign wb_zero    = wb_elig && !blocked_q && (size_q[wb_q] == '0);
  assign req_valid  = wb_elig && (size_q[wb_q] != '0) && (!blocked_q || retry_in);
  assign wb_sent    = req_valid && req_ready;
  assign wb_refused = req_valid && !req_ready;
  assign req_idx    = wb_q;
  assign req_size   = size_q[wb_q];
  assign req_data   = data_q[wb_q];

  assign store_done = rsp_valid || wb_zero;
  assign ready_now  = ready_q | ready_set;
  assign done_now   = done_q
                    | (rsp_valid ? (N'(1) << rsp_idx) : '0)
                    | (wb_zero   ? (N'(1) << wb_q)    : '0);

  sq_commit_scan #(.N(N), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_commit (
    .head(head_q), .tail(tail_q), .commit_valid(commit_valid),
    .commit_seq(commit_seq), .seq(seq_q), .ready_q(ready_q),
    .ready_set(ready_set)
  );

  sq_squash_scan #(.N(N), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_squash (
    .head(head_q), .tail(tail_q), .squash_valid(squash_valid),
    .squash_seq(squash_seq), .seq(seq_q), .ready_now(ready_now),
    .cut_tail(cut_tail)
  );

  sq_head_scan #(.N(N), .IDX_W(IDX_W)) u_head (
    .head(head_q), .tail(tail_q), .done_now(done_now),
    .new_head(new_head), .release_mask(release_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      wb_q       <= '0;
      ready_q    <= '0;
      done_q     <= '0;
      blocked_q  <= 1'b0;
      inflight_q <= 1'b0;
      for (int i = 0; i < N; i++) begin
        seq_q[i]  <= '0;
        size_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      head_q  <= new_head;
      ready_q <= ready_now & ~release_mask;
      done_q  <= done_now & ~release_mask;
      if (squash_valid) begin
        tail_q <= cut_tail;
      end else if (alloc_take) begin
        tail_q          <= ring_next(tail_q);
        seq_q[tail_q]   <= alloc_seq;
        size_q[tail_q]  <= '0;
        data_q[tail_q]  <= '0;
        ready_q[tail_q] <= 1'b0;
        done_q[tail_q]  <= 1'b0;
      end
      if (exec_valid) begin
        size_q[exec_idx] <= exec_size;
        data_q[exec_idx] <= exec_data;
      end
      if (wb_zero || wb_sent) wb_q <= ring_next(wb_q);
      if (wb_sent)         blocked_q <= 1'b0;
      else if (wb_refused) blocked_q <= 1'b1;
      if (wb_sent && tso_order) inflight_q <= 1'b1;
      else if (store_done)      inflight_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sq_store_queue_chk.sv
module sq_store_queue_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             squash_valid,
  input logic [CNT_W-1:0] free_cnt,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IDX_W-1:0] req_idx,
  input logic             retry_in,
  input logic             wb_blocked,
  input logic             wb_zero,
  input logic             tso_busy
);
  // R2
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) <= DEPTH);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0 && alloc_valid && !squash_valid) |=> $stable(alloc_idx));

  // R5
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (req_idx != $past(req_idx)));

  // R6
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_zero |-> !req_valid);

  // R7
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_blocked && !retry_in) |-> !req_valid);

  // R9
  squash_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (free_cnt >= $past(free_cnt)));

  // R10
  tso_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tso_busy |-> !req_valid);
endmodule

bind sq_store_queue sq_store_queue_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
  .squash_valid(squash_valid), .free_cnt(free_cnt), .alloc_idx(alloc_idx),
  .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
  .retry_in(retry_in), .wb_blocked(wb_blocked), .wb_zero(wb_zero),
  .tso_busy(tso_busy)
);

// File: tb/tb_sq_store_queue.sv
`timescale 1ns/1ps
module tb_sq_store_queue;
  localparam int DEPTH  = 4;
  localparam int SEQ_W  = 8;
  localparam int DATA_W = 16;
  localparam int SIZE_W = 3;
  localparam int N      = DEPTH + 1;
  localparam int IDX_W  = $clog2(N);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n, tso_order;
  logic alloc_valid, exec_valid, commit_valid, squash_valid;
  logic [SEQ_W-1:0]  alloc_seq, commit_seq, squash_seq;
  logic [IDX_W-1:0]  alloc_idx, exec_idx, req_idx, rsp_idx;
  logic [CNT_W-1:0]  free_cnt;
  logic [SIZE_W-1:0] exec_size, req_size;
  logic [DATA_W-1:0] exec_data, req_data;
  logic req_valid, req_ready, retry_in, rsp_valid;

  always #4 clk = ~clk;

  sq_store_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) dut (
    .clk(clk), .rst_n(rst_n), .tso_order(tso_order),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
    .free_cnt(free_cnt), .exec_valid(exec_valid), .exec_idx(exec_idx),
    .exec_size(exec_size), .exec_data(exec_data), .commit_valid(commit_valid),
    .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_size(req_size), .req_data(req_data), .retry_in(retry_in),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Reference model: plain ring of slots with integer pointers
  int m_seq [N];
  int m_size[N];
  int m_data[N];
  bit m_rdy [N];
  bit m_done[N];
  int m_head, m_tail, m_wb;
  bit m_blk, m_infl;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nx(input int p); return (p + 1) % N; endfunction
  function automatic int pv(input int p); return (p + N - 1) % N; endfunction
  function automatic int m_occ(); return (m_tail - m_head + N) % N; endfunction
  function automatic bit m_elig();
    return (m_wb != m_tail) && m_rdy[m_wb] && !(tso_order && m_infl);
  endfunction
  function automatic bit m_req();
    return m_elig() && m_size[m_wb] != 0 && (!m_blk || retry_in);
  endfunction
  function automatic bit m_zero();
    return m_elig() && !m_blk && m_size[m_wb] == 0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_seq[i] = 0; m_size[i] = 0; m_data[i] = 0; m_rdy[i] = 0; m_done[i] = 0;
    end
    m_head = 0; m_tail = 0; m_wb = 0; m_blk = 0; m_infl = 0;
  endtask

  task automatic m_step();
    bit zero, req, fire;
    int p;
    zero = m_zero();
    req  = m_req();
    fire = req && req_ready;
    if (commit_valid) begin
      p = m_head;
      while (p != m_tail) begin
        if (!m_rdy[p]) begin
          if (m_seq[p] > int'(commit_seq)) break;
          m_rdy[p] = 1;
        end
        p = nx(p);
      end
    end
    if (squash_valid) begin
      while (m_tail != m_head) begin
        p = pv(m_tail);
        if (m_rdy[p] || m_seq[p] <= int'(squash_seq)) break;
        m_tail = p;
      end
    end else if (alloc_valid && m_occ() < DEPTH) begin
      m_seq[m_tail] = int'(alloc_seq); m_size[m_tail] = 0; m_data[m_tail] = 0;
      m_rdy[m_tail] = 0; m_done[m_tail] = 0;
      m_tail = nx(m_tail);
    end
    if (exec_valid) begin
      m_size[exec_idx] = int'(exec_size);
      m_data[exec_idx] = int'(exec_data);
    end
    if (rsp_valid) m_done[rsp_idx] = 1;
    if (zero) m_done[m_wb] = 1;
    if (zero || fire) m_wb = nx(m_wb);
    if (fire) m_blk = 0;
    else if (req && !req_ready) m_blk = 1;
    if (fire && tso_order) m_infl = 1;
    else if (rsp_valid || zero) m_infl = 0;
    while (m_head != m_tail && m_done[m_head]) begin
      m_done[m_head] = 0; m_rdy[m_head] = 0;
      m_head = nx(m_head);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_seq = '0; exec_valid = 0; exec_idx = '0;
    exec_size = '0; exec_data = '0; commit_valid = 0; commit_seq = '0;
    squash_valid = 0; squash_seq = '0; req_ready = 1; retry_in = 0;
    rsp_valid = 0; rsp_idx = '0;
  endtask

  // Compare every output on the falling edge, then step the model at the rising edge
  task automatic cyc();
    @(negedge clk);
    check("R5 req_valid", int'(req_valid), int'(m_req()));
    if (m_req()) begin
      check("R5 req_idx", int'(req_idx), m_wb);
      check("R5 req_size", int'(req_size), m_size[m_wb]);
      check("R5 req_data", int'(req_data), m_data[m_wb]);
    end
    check("R2 free_cnt", int'(free_cnt), DEPTH - m_occ());
    check("R2 alloc_idx", int'(alloc_idx), m_tail);
    @(posedge clk);
    m_step();
    #1;
    idle();
  endtask

  task automatic look(); #1; endtask

  task automatic alloc(input int s); alloc_valid = 1; alloc_seq = SEQ_W'(s); endtask
  task automatic exec(input int i, input int sz, input int d);
    exec_valid = 1; exec_idx = IDX_W'(i); exec_size = SIZE_W'(sz); exec_data = DATA_W'(d);
  endtask
  task automatic commit(input int s); commit_valid = 1; commit_seq = SEQ_W'(s); endtask
  task automatic squash(input int s); squash_valid = 1; squash_seq = SEQ_W'(s); endtask
  task automatic rsp(input int i); rsp_valid = 1; rsp_idx = IDX_W'(i); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; tso_order = 0; idle();
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look();
    check("R1 free_cnt", int'(free_cnt), DEPTH);
    check("R1 alloc_idx", int'(alloc_idx), 0);
    check("R1 req_valid", int'(req_valid), 0);

    // Fill the ring, then try one more
    alloc(10); cyc();
    alloc(11); exec(0, 4, 'hA0A0); cyc();
    alloc(12); exec(1, 0, 0); cyc();
    alloc(13); exec(2, 2, 'h00C2); cyc();
    alloc(14); exec(3, 1, 'h00D3); cyc(); look();
    check("R2 full free_cnt", int'(free_cnt), 0);
    check("R3 dropped alloc_idx", int'(alloc_idx), 4);

    // Commit two of four; refuse the first request
    commit(11); cyc(); look();
    check("R4 req_valid", int'(req_valid), 1);
    check("R4 req_idx", int'(req_idx), 0);
    req_ready = 0; cyc(); look();
    check("R7 blocked req_valid", int'(req_valid), 0);
    cyc(); look();
    check("R7 still blocked", int'(req_valid), 0);
    check("R7 held idx", int'(req_idx), 0);
    retry_in = 1; cyc(); look();
    check("R6 zero size no request", int'(req_valid), 0);
    cyc(); look();
    check("R4 uncommitted stays", int'(req_valid), 0);
    check("R8 head waits", int'(free_cnt), 0);

    // Squash stops at the committed store in slot 1
    squash(11); cyc(); look();
    check("R9 alloc_idx", int'(alloc_idx), 2);
    check("R9 free_cnt", int'(free_cnt), 2);
    rsp(0); cyc(); look();
    check("R8 head frees run", int'(free_cnt), 4);

    // Single store in flight
    tso_order = 1;
    alloc(20); cyc();
    alloc(21); exec(2, 2, 'h0022); cyc();
    exec(3, 2, 'h0033); commit(21); cyc(); look();
    check("R10 first offered", int'(req_idx), 2);
    cyc(); look();
    check("R10 second held", int'(req_valid), 0);
    rsp(2); cyc(); look();
    check("R10 second offered", int'(req_valid), 1);
    check("R10 second idx", int'(req_idx), 3);
    check("R8 partial free", int'(free_cnt), 3);
    cyc();
    rsp(3); cyc(); look();
    check("R8 all free", int'(free_cnt), 4);
    tso_order = 0;

    // Relaxed mode across the wrap, responses out of order
    alloc(30); cyc();
    alloc(31); exec(4, 3, 'h0044); cyc(); look();
    check("R2 wrapped alloc_idx", int'(alloc_idx), 1);
    exec(0, 1, 'h0055); commit(31); cyc(); look();
    check("R5 first idx", int'(req_idx), 4);
    cyc(); look();
    check("R5 back to back", int'(req_valid), 1);
    check("R5 back to back idx", int'(req_idx), 0);
    cyc(); look();
    check("R5 drained", int'(req_valid), 0);
    rsp(0); cyc(); look();
    check("R8 out of order held", int'(free_cnt), 2);
    rsp(4); cyc(); look();
    check("R8 out of order freed", int'(free_cnt), 4);
    cyc();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule